// File: doc/BRIEF.md
# Multi-Cycle Shift and Rotate Unit with Carry

This unit applies one of eight shift or rotate operations to an 8-bit or 16-bit operand. A multi-bit count is carried out as a sequence of single-bit steps, one per clock. The carry flag is threaded through every step, and the overflow flag is updated after each step. A start pulse hands the unit an operation code, a size select, the operand, a count and the incoming carry. When the last step is complete, the unit raises a one-cycle done pulse, and at that moment the result, carry and overflow outputs hold their final values.

The unit sits beside the main ALU of a small processor core. Operand fetch and every other ALU operation are outside it. The count may come from an immediate or from a count register; either way, only its low five bits are used. The outputs keep their values between operations, so the core can read them at any time after done.

Top module: `shift_rotate_unit`

## Requirements
- R1: After a synchronous active-low reset, result, cf_out, of_out and done are all zero.
- R2: Plain rotates (op 0 = rotate left, op 1 = rotate right) copy the bit that leaves one end into the vacated bit at the other end and into CF. In 8-bit mode, 1Ch rotated left by 1 gives 38h, and rotated right by 1 gives 0Eh; CF is 0 in both cases.
- R3: Rotates through carry (op 2 = left, op 3 = right) put the old CF into the vacated bit and the leaving bit into CF. In 8-bit mode with CF=1, 1Ch gives 39h for a left rotate and 8Eh for a right rotate, with CF=0 in both cases. A 16-bit rotate through carry by 17, or an 8-bit one by 9, returns the operand unchanged.
- R4: Left shifts (op 4 = logical, op 6 = arithmetic) fill bit 0 with zero and send the leaving top bit to CF. In 8-bit mode, E0h gives C0h with CF=1.
- R5: The logical right shift (op 5) fills the top bit with zero: 07h gives 03h with CF=1. The arithmetic right shift (op 7) copies the sign bit into the top bit: E0h gives F0h and 4Ch gives 26h.
- R6: A count of N (N from 1 to 31) is applied as N single-bit steps, one per clock. If start is sampled at clock edge k, done is high for exactly the one cycle that follows edge k+N.
- R7: After a nonzero count, of_out is 1 exactly when the sign bit of the result differs from the sign bit of the original operand.
- R8: Only count bits [4:0] are used; a count of 21h acts as 1 and a count of 20h acts as 0.
- R9: A count of zero produces done in the cycle after start. In that case result equals the operand (width-masked), cf_out equals cf_in, and of_out keeps its previous value.
- R10: When wide=0, only operand bits [7:0] are used, bit 7 is the sign and end bit, and result[15:8] reads zero. When wide=1, all 16 bits are used.
- R11: A start pulse that arrives while an operation is in progress is ignored. It produces no extra done pulse and does not alter the result.
- R12: While the unit is idle and start is low, result, cf_out and of_out hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code (see R2 to R5) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| operand | input | DATA_W | Value to shift or rotate |
| count | input | CNT_IN_W | Step count; only the low CNT_W bits are used |
| cf_in | input | 1 | Incoming carry flag |
| result | output | DATA_W | Shifted or rotated value |
| cf_out | output | 1 | Carry flag |
| of_out | output | 1 | Overflow flag |
| done | output | 1 | One-cycle pulse marking the final result |

## Verification
The bench builds the unit with its defaults: DATA_W 16, NARROW_W 8, CNT_W 5 and CNT_IN_W 8. Because the count input is wider than the five-bit mask, counts of 32 and above reach the masking path. The 31-step maximum is kept short enough that full-circle rotates through carry fit in a run: 17 steps in 16-bit mode and 9 steps in 8-bit mode. With both widths present, the choice of sign bit and end bit is exercised for every operation, and a sweep covers all eight operations at both sizes, including counts that exceed the mask.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes for the shift and rotate unit.
// Assumes a 3-bit operation field driven by the core's decoder.
package sru_pkg;
    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } sru_op_e;
endpackage

// File: rtl/sru_bitstep.sv
`timescale 1ns/1ps
// Module: sru_bitstep
// Performs one single-bit shift or rotate step on the working value.
// Assumes: in narrow mode, the bits above NARROW_W-1 of val are zero.
module sru_bitstep
    import sru_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  sru_op_e             op,
    input  logic                wide,
    input  logic [DATA_W-1:0]   val,
    input  logic                cf,
    output logic [DATA_W-1:0]   nxt,
    output logic                cf_nxt
);
    localparam logic [DATA_W-1:0] NMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [DATA_W-1:0] TOP_W = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] TOP_N = {{(DATA_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

    logic hi_bit, lo_bit, fill, go_left;
    logic [DATA_W-1:0] mask, top_sel;

    // Select end bits, fill rule and direction for the operation.
    always_comb begin
        hi_bit  = wide ? val[DATA_W-1] : val[NARROW_W-1];
        lo_bit  = val[0];
        mask    = wide ? '1 : NMASK;
        top_sel = wide ? TOP_W : TOP_N;
        go_left = (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
        unique case (op)
            OP_ROL:         fill = hi_bit;
            OP_ROR:         fill = lo_bit;
            OP_RCL, OP_RCR: fill = cf;
            OP_SAR:         fill = hi_bit;
            default:        fill = 1'b0;
        endcase
    end

    // Form the stepped value and the bit that leaves it.
    always_comb begin
        if (go_left) begin
            nxt    = ((val << 1) | {{(DATA_W-1){1'b0}}, fill}) & mask;
            cf_nxt = hi_bit;
        end else begin
            nxt    = (val >> 1) | (fill ? top_sel : '0);
            cf_nxt = lo_bit;
        end
    end
endmodule

// File: rtl/sru_sequencer.sv
`timescale 1ns/1ps
// Module: sru_sequencer
// Counts the single-bit steps that remain and flags the last one.
// Assumes load is asserted only while busy is low.
module sru_sequencer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             busy,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    // Load the step count, then count it down one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            remain <= load_cnt;
            busy   <= (load_cnt != '0);
        end else if (busy) begin
            remain <= remain - 1'b1;
            if (remain == {{(CNT_W-1){1'b0}}, 1'b1}) busy <= 1'b0;
        end
    end

    assign last = busy && (remain == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
// Module: shift_rotate_unit
// Top level: accepts one operation at a time, steps it one bit per
// clock, tracks CF and OF, and pulses done with the final value.
// Assumes the caller keeps start low until done when it needs every
// start honoured; starts that arrive while busy are dropped.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 5,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          op,
    input  logic                wide,
    input  logic [DATA_W-1:0]   operand,
    input  logic [CNT_IN_W-1:0] count,
    input  logic                cf_in,
    output logic [DATA_W-1:0]   result,
    output logic                cf_out,
    output logic                of_out,
    output logic                done
);
    localparam logic [DATA_W-1:0] NMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic              busy, last, accept;
    logic [CNT_W-1:0]  cnt_m;
    logic [DATA_W-1:0] opnd_m, acc, step_val;
    logic              cf_q, of_q, done_q, wide_q, sign_q, step_cf, step_sign;
    sru_op_e           op_q;

    assign accept    = start && !busy;
    assign cnt_m     = count[CNT_W-1:0];
    assign opnd_m    = wide ? operand : (operand & NMASK);
    assign step_sign = wide_q ? step_val[DATA_W-1] : step_val[NARROW_W-1];

    // Count bits above the mask are dropped by design.
    generate
        if (CNT_IN_W > CNT_W) begin : g_cnt_drop
            logic unused_cnt_hi;
            assign unused_cnt_hi = ^count[CNT_IN_W-1:CNT_W];
        end
    endgenerate

    sru_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_cnt (cnt_m),
        .busy     (busy),
        .last     (last)
    );

    sru_bitstep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .op     (op_q),
        .wide   (wide_q),
        .val    (acc),
        .cf     (cf_q),
        .nxt    (step_val),
        .cf_nxt (step_cf)
    );

    // Capture a new operation, or advance the one in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            cf_q   <= 1'b0;
            of_q   <= 1'b0;
            done_q <= 1'b0;
            wide_q <= 1'b0;
            sign_q <= 1'b0;
            op_q   <= OP_ROL;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                acc    <= opnd_m;
                cf_q   <= cf_in;
                wide_q <= wide;
                op_q   <= sru_op_e'(op);
                sign_q <= wide ? operand[DATA_W-1] : operand[NARROW_W-1];
                if (cnt_m == '0) done_q <= 1'b1;
            end else if (busy) begin
                acc    <= step_val;
                cf_q   <= step_cf;
                of_q   <= step_sign ^ sign_q;
                if (last) done_q <= 1'b1;
            end
        end
    end

    assign result = acc;
    assign cf_out = cf_q;
    assign of_out = of_q;
    assign done   = done_q;
endmodule

// File: rtl/sru_chk.sv
`timescale 1ns/1ps
// Module: sru_chk
// Property checker for shift_rotate_unit, attached by bind below.
// Keeps its own copy of the width and sign of each accepted operand.
module sru_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wide,
    input logic [DATA_W-1:0] operand,
    input logic [CNT_W-1:0]  cnt_lo,
    input logic              cf_in,
    input logic [DATA_W-1:0] result,
    input logic              cf_out,
    input logic              of_out,
    input logic              done,
    input logic              busy
);
    localparam logic [DATA_W-1:0] NMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic c_wide, c_sign;

    // Record the size and sign of each operation the unit takes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_wide <= 1'b0;
            c_sign <= 1'b0;
        end else if (start && !busy) begin
            c_wide <= wide;
            c_sign <= wide ? operand[DATA_W-1] : operand[NARROW_W-1];
        end
    end

    // R9: zero count finishes next cycle with operand, carry in, OF held
    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (cnt_lo == '0) |=> done && (cf_out == $past(cf_in)) && $stable(of_out)
            && (result == $past(wide ? operand : (operand & NMASK))));

    // R6: a nonzero count starts stepping without an immediate done
    p_step_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (cnt_lo != '0) |=> busy && !done);

    // R12: idle with no start keeps every output steady
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(result) && $stable(cf_out) && $stable(of_out));

    // R10: narrow results never carry bits above the narrow width
    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !c_wide |-> (result[DATA_W-1:NARROW_W] == '0));

    // R7: after stepping, OF marks a change of sign
    p_of_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |-> of_out == ((c_wide ? result[DATA_W-1] : result[NARROW_W-1]) ^ c_sign));
endmodule

bind shift_rotate_unit sru_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wide    (wide),
    .operand (operand),
    .cnt_lo  (count[CNT_W-1:0]),
    .cf_in   (cf_in),
    .result  (result),
    .cf_out  (cf_out),
    .of_out  (of_out),
    .done    (done),
    .busy    (busy)
);

// File: tb/sim_shift_rotate_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: issue() predicts and queues, the monitor compares at done.
module sim_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] operand = '0;
    logic [7:0]  count = '0;
    logic        cf_in = 1'b0;
    logic [15:0] result;
    logic        cf_out, of_out, done;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic last_of = 1'b0;
    logic [15:0] last_res = '0;
    logic last_cf = 1'b0;

    typedef struct packed {
        logic [15:0] res;
        logic        cf;
        logic        of;
        int          due;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_rotate_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .operand(operand), .count(count), .cf_in(cf_in),
        .result(result), .cf_out(cf_out), .of_out(of_out), .done(done)
    );

    // Reference: apply n single-bit steps per the requirement rules.
    function automatic logic [16:0] ref_run(input int o, input bit w, input logic [15:0] v,
                                            input logic c, input int n);
        logic [15:0] r;
        logic cc, hi, lo;
        int top;
        r = v;
        cc = c;
        top = w ? 15 : 7;
        for (int k = 0; k < n; k++) begin
            hi = r[top];
            lo = r[0];
            case (o)
                0: begin r = (r << 1) | {15'd0, hi}; cc = hi; end
                1: begin r = r >> 1; r[top] = lo; cc = lo; end
                2: begin r = (r << 1) | {15'd0, cc}; cc = hi; end
                3: begin r = r >> 1; r[top] = cc; cc = lo; end
                5: begin r = r >> 1; cc = lo; end
                7: begin r = r >> 1; r[top] = hi; cc = lo; end
                default: begin r = r << 1; cc = hi; end
            endcase
            if (!w) r[15:8] = 8'h00;
        end
        return {cc, r};
    endfunction

    // Driver: predict, queue, pulse start, wait for the result.
    task automatic issue(input int o, input bit w, input logic [15:0] v,
                         input logic [7:0] cnt, input logic c, input string tag);
        exp_t e;
        logic [16:0] rr;
        logic [15:0] vm;
        int n;
        n  = int'(cnt & 8'h1F);
        vm = w ? v : {8'h00, v[7:0]};
        if (n == 0) begin
            e.res = vm; e.cf = c; e.of = last_of;
        end else begin
            rr = ref_run(o, w, vm, c, n);
            e.res = rr[15:0]; e.cf = rr[16];
            e.of = (w ? rr[15] : rr[7]) ^ (w ? vm[15] : vm[7]);
        end
        last_of = e.of; last_res = e.res; last_cf = e.cf;
        @(negedge clk);
        op = o[2:0]; wide = w; operand = v; count = cnt; cf_in = c; start = 1'b1;
        e.due = cyc + 1 + n;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    // Monitor: compare each done against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            if (exp_q.size() == 0) begin
                vectors++; fails++;
                $display("FAIL R11 unexpected done: actual done=1 expected done=0");
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (result !== e.res || cf_out !== e.cf || of_out !== e.of || cyc != e.due) begin
                    fails++;
                    $display("FAIL %s: actual res=%h cf=%b of=%b cyc=%0d expected res=%h cf=%b of=%b cyc=%0d",
                             t, result, cf_out, of_out, cyc, e.res, e.cf, e.of, e.due);
                end
            end
        end
    end

    task automatic check_hold(input string tag);
        repeat (5) @(negedge clk);
        vectors++;
        if (result !== last_res || cf_out !== last_cf || of_out !== last_of || done !== 1'b0) begin
            fails++;
            $display("FAIL %s: actual res=%h cf=%b of=%b expected res=%h cf=%b of=%b",
                     tag, result, cf_out, of_out, last_res, last_cf, last_of);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        vectors++;
        if (result !== 16'h0 || cf_out !== 1'b0 || of_out !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual res=%h cf=%b of=%b done=%b expected all zero",
                     result, cf_out, of_out, done);
        end
        rst_n = 1'b1;
        issue(0, 0, 16'h001C, 8'd1, 1'b0, "R2 rol 1Ch");
        issue(1, 0, 16'h001C, 8'd1, 1'b1, "R2 ror 1Ch");
        issue(2, 0, 16'h001C, 8'd1, 1'b1, "R3 rcl 1Ch");
        issue(3, 0, 16'h001C, 8'd1, 1'b1, "R3 rcr 1Ch");
        issue(3, 1, 16'hB6E1, 8'd17, 1'b1, "R3 rcr16 by 17");
        issue(2, 0, 16'h005A, 8'd9, 1'b0, "R3 rcl8 by 9");
        issue(4, 0, 16'h00E0, 8'd1, 1'b0, "R4 shl E0h");
        issue(6, 0, 16'h00E0, 8'd1, 1'b0, "R4 sal E0h");
        issue(5, 0, 16'h0007, 8'd1, 1'b0, "R5 shr 07h");
        issue(7, 0, 16'h00E0, 8'd1, 1'b0, "R5 sar E0h");
        issue(7, 0, 16'h004C, 8'd1, 1'b0, "R5 sar 4Ch");
        issue(0, 1, 16'h8001, 8'd4, 1'b0, "R6 rol16 by 4");
        issue(5, 1, 16'hFFFF, 8'd31, 1'b0, "R6 shr16 by 31");
        issue(0, 0, 16'h0081, 8'd1, 1'b0, "R7 rol sign change");
        issue(4, 0, 16'h0081, 8'h21, 1'b0, "R8 count 21h");
        issue(4, 0, 16'h0081, 8'h20, 1'b1, "R8 count 20h");
        issue(1, 1, 16'h1234, 8'd0, 1'b0, "R9 zero count");
        issue(4, 0, 16'hABCD, 8'd3, 1'b1, "R10 narrow upper");
        issue(7, 1, 16'h8421, 8'd3, 1'b0, "R10 wide sar");
        check_hold("R12 idle hold");
        // R11: a start during a 10-step rotate is dropped
        begin
            exp_t e;
            logic [16:0] rr;
            rr = ref_run(0, 1'b1, 16'h8C31, 1'b0, 10);
            e.res = rr[15:0]; e.cf = rr[16]; e.of = rr[15] ^ 1'b1;
            last_of = e.of; last_res = e.res; last_cf = e.cf;
            @(negedge clk);
            op = 3'd0; wide = 1'b1; operand = 16'h8C31; count = 8'd10; cf_in = 1'b0; start = 1'b1;
            e.due = cyc + 11;
            exp_q.push_back(e);
            tag_q.push_back("R11 start while busy");
            @(negedge clk); start = 1'b0;
            repeat (3) @(negedge clk);
            op = 3'd5; operand = 16'h0F0F; count = 8'd0; cf_in = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (exp_q.size() != 0) @(posedge clk);
            repeat (12) @(negedge clk);
        end
        check_hold("R12 hold after R11");
        // R6 sweep across every operation, both sizes, counts past the mask
        for (int i = 0; i < 64; i++) begin
            logic [15:0] sv;
            logic [7:0]  sc;
            sv = 16'h9D3B ^ (16'(i) * 16'h0517);
            sc = 8'((i * 7) % 40);
            issue(i % 8, (i / 8) % 2 == 1, sv, sc, i[1], "R6 sweep");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++; fails++;
            $display("FAIL R6 watchdog: actual no done expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule